// File: doc/BRIEF.md
# BCD Calendar Counter with Leap Years

This block keeps the time of day and the calendar date. It presents seven fields as packed BCD: seconds, minutes, hours, day of week, day of month, month and a three-digit year. A prescaler counts cycles of the reference clock (32768 per second by default). It produces one seconds strobe per full count, and each strobe advances the calendar by one second. The carries run through minutes, hours, days, months and years. Month lengths and Gregorian leap years are handled, including the century exceptions.

A single master enable input runs the block. While it is high, time advances and software may load any subset of fields through a per-field write mask. While it is low, time stands still and writes are dropped. Each rising edge of the enable restarts the prescaler from a full period. The year field holds only the last three digits. A parameter supplies the base century that is added before the leap-year test.

Top module: `bcd_calendar`

## Requirements
- R1: After the clock edge that first samples `enable` high following a low, the first seconds step lands exactly `TICKS_PER_SEC` edges later, and further steps follow every `TICKS_PER_SEC` edges while `enable` stays high.
- R2: Seconds step 59 to 00 and carry one into minutes. Minutes step 59 to 00 and carry into hours. Hours step 23 to 00 and end the day.
- R3: Day of week runs 0 to 6 and returns to 0, advancing by one at every day end.
- R4: Day of month runs from 1 up to the month length and then returns to 1 while the month advances. Lengths for months 1 to 12 are 31, 28 or 29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31.
- R5: February has 29 days when the full year (`BASE_CENTURY` plus the 3-digit year) is divisible by 4 and is either not divisible by 100 or divisible by 400.
- R6: Month is BCD 0x01 to 0x12; after 0x12 it returns to 0x01 and the year increments. The year is three BCD digits in bits [11:0] and returns from 0x999 to 0x000.
- R7: While `enable` is low, no field changes.
- R8: A write presented while `enable` is low is ignored; all fields keep their values.
- R9: Reset sets time 00:00:00, day of week 0, day 0x01, month 0x01, year 0x000.
- R10: When a field write and a seconds step fall on the same edge, each written field takes the written value. Unwritten fields still take the stepped value, carries included.
- R11: `wrMask` bit 0 selects seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. With `enable` high, a selected field shows its BCD write data after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master enable: runs the clock and permits writes |
| wrMask | input | 7 | Per-field write select |
| wrSec | input | 8 | BCD seconds to write |
| wrMin | input | 8 | BCD minutes to write |
| wrHour | input | 8 | BCD hours to write |
| wrWday | input | 8 | BCD day of week to write |
| wrMday | input | 8 | BCD day of month to write |
| wrMon | input | 8 | BCD month to write |
| wrYear | input | 12 | BCD 3-digit year to write |
| secBcd | output | 8 | Current seconds |
| minBcd | output | 8 | Current minutes |
| hourBcd | output | 8 | Current hours |
| wdayBcd | output | 8 | Current day of week |
| mdayBcd | output | 8 | Current day of month |
| monBcd | output | 8 | Current month |
| yearBcd | output | 12 | Current year, three digits |

## Verification
A software write and a seconds step can land on the same edge. The bench provokes this by loading a time ending in 59 seconds, which restarts the prescaler at a known edge. It then counts edges and writes only the seconds field on the edge the step is due. The result is judged correct when seconds show the written value while minutes still show the carry of the step.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

  localparam int FIELD_CNT = 7;

  typedef struct packed {
    logic                 secTick;
    logic [FIELD_CNT-1:0] wrStb;
  } calCtrl_t;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [6:0] wday;
    logic [6:0] mday;
    logic [6:0] mon;
    logic [9:0] year;
  } calTime_t;

  function automatic logic [6:0] bcdToBin(input logic [7:0] b);
    logic [6:0] hi;
    hi = {3'b000, b[7:4]};
    return hi * 7'd10 + {3'b000, b[3:0]};
  endfunction

  function automatic logic [7:0] binToBcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [9:0] bcdToYear(input logic [11:0] b);
    return {6'd0, b[11:8]} * 10'd100 + {6'd0, b[7:4]} * 10'd10 + {6'd0, b[3:0]};
  endfunction

  function automatic logic [11:0] yearToBcd(input logic [9:0] v);
    logic [9:0] h;
    logic [9:0] t;
    logic [9:0] o;
    h = v / 10'd100;
    t = (v / 10'd10) % 10'd10;
    o = v % 10'd10;
    return {h[3:0], t[3:0], o[3:0]};
  endfunction

  function automatic logic [6:0] monthDays(input logic [6:0] mon, input logic leap);
    case (mon)
      7'd2:                      return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_calendar_ctrl.sv
module bcd_calendar_ctrl
  import bcd_calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [FIELD_CNT-1:0] wrMask,
  output calCtrl_t             ctrl
);
  localparam int CW = $clog2(TICKS_PER_SEC + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic          enPrev;
  logic [CW-1:0] cnt;
  logic          enRise;

  assign enRise = enable & ~enPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      cnt    <= '0;
    end else begin
      enPrev <= enable;
      if (enRise) begin
        cnt <= '0;
      end else if (enable) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.secTick = enable & ~enRise & (cnt == LAST);
    ctrl.wrStb   = enable ? wrMask : '0;
  end
endmodule

// File: rtl/bcd_calendar_dp.sv
module bcd_calendar_dp
  import bcd_calendar_pkg::*;
#(
  parameter int BASE_CENTURY = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  calCtrl_t    ctrl,
  input  logic [7:0]  wrSec,
  input  logic [7:0]  wrMin,
  input  logic [7:0]  wrHour,
  input  logic [7:0]  wrWday,
  input  logic [7:0]  wrMday,
  input  logic [7:0]  wrMon,
  input  logic [11:0] wrYear,
  output logic [7:0]  secBcd,
  output logic [7:0]  minBcd,
  output logic [7:0]  hourBcd,
  output logic [7:0]  wdayBcd,
  output logic [7:0]  mdayBcd,
  output logic [7:0]  monBcd,
  output logic [11:0] yearBcd
);
  localparam logic [15:0] BASE = 16'(BASE_CENTURY);

  calTime_t   cur;
  calTime_t   nxt;
  logic [15:0] fullYear;
  logic        leap;
  logic [6:0]  monLen;

  assign fullYear = BASE + {6'd0, cur.year};
  assign leap     = (fullYear[1:0] == 2'b00) &&
                    (((fullYear % 16'd100) != 16'd0) || ((fullYear % 16'd400) == 16'd0));
  assign monLen   = monthDays(cur.mon, leap);

  always_comb begin
    nxt = cur;
    if (ctrl.secTick) begin
      if (cur.sec >= 7'd59) begin
        nxt.sec = 7'd0;
        if (cur.min >= 7'd59) begin
          nxt.min = 7'd0;
          if (cur.hour >= 7'd23) begin
            nxt.hour = 7'd0;
            nxt.wday = (cur.wday >= 7'd6) ? 7'd0 : cur.wday + 7'd1;
            if (cur.mday >= monLen) begin
              nxt.mday = 7'd1;
              if (cur.mon >= 7'd12) begin
                nxt.mon  = 7'd1;
                nxt.year = (cur.year >= 10'd999) ? 10'd0 : cur.year + 10'd1;
              end else begin
                nxt.mon = cur.mon + 7'd1;
              end
            end else begin
              nxt.mday = cur.mday + 7'd1;
            end
          end else begin
            nxt.hour = cur.hour + 7'd1;
          end
        end else begin
          nxt.min = cur.min + 7'd1;
        end
      end else begin
        nxt.sec = cur.sec + 7'd1;
      end
    end
    if (ctrl.wrStb[0]) nxt.sec  = bcdToBin(wrSec);
    if (ctrl.wrStb[1]) nxt.min  = bcdToBin(wrMin);
    if (ctrl.wrStb[2]) nxt.hour = bcdToBin(wrHour);
    if (ctrl.wrStb[3]) nxt.wday = bcdToBin(wrWday);
    if (ctrl.wrStb[4]) nxt.mday = bcdToBin(wrMday);
    if (ctrl.wrStb[5]) nxt.mon  = bcdToBin(wrMon);
    if (ctrl.wrStb[6]) nxt.year = bcdToYear(wrYear);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '{sec: 7'd0, min: 7'd0, hour: 7'd0, wday: 7'd0,
               mday: 7'd1, mon: 7'd1, year: 10'd0};
    end else begin
      cur <= nxt;
    end
  end

  assign secBcd  = binToBcd(cur.sec);
  assign minBcd  = binToBcd(cur.min);
  assign hourBcd = binToBcd(cur.hour);
  assign wdayBcd = binToBcd(cur.wday);
  assign mdayBcd = binToBcd(cur.mday);
  assign monBcd  = binToBcd(cur.mon);
  assign yearBcd = yearToBcd(cur.year);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BASE_CENTURY  = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [6:0]  wrMask,
  input  logic [7:0]  wrSec,
  input  logic [7:0]  wrMin,
  input  logic [7:0]  wrHour,
  input  logic [7:0]  wrWday,
  input  logic [7:0]  wrMday,
  input  logic [7:0]  wrMon,
  input  logic [11:0] wrYear,
  output logic [7:0]  secBcd,
  output logic [7:0]  minBcd,
  output logic [7:0]  hourBcd,
  output logic [7:0]  wdayBcd,
  output logic [7:0]  mdayBcd,
  output logic [7:0]  monBcd,
  output logic [11:0] yearBcd
);
  calCtrl_t ctrl;

  bcd_calendar_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .wrMask(wrMask), .ctrl(ctrl)
  );

  bcd_calendar_dp #(.BASE_CENTURY(BASE_CENTURY)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .wrSec(wrSec), .wrMin(wrMin), .wrHour(wrHour), .wrWday(wrWday),
    .wrMday(wrMday), .wrMon(wrMon), .wrYear(wrYear),
    .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd), .wdayBcd(wdayBcd),
    .mdayBcd(mdayBcd), .monBcd(monBcd), .yearBcd(yearBcd)
  );
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic [6:0]  wrMask,
  input logic [7:0]  wrSec,
  input logic [7:0]  secBcd,
  input logic [7:0]  minBcd,
  input logic [7:0]  hourBcd,
  input logic [7:0]  wdayBcd,
  input logic [7:0]  mdayBcd,
  input logic [7:0]  monBcd,
  input logic [11:0] yearBcd
);
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable({secBcd, minBcd, hourBcd, wdayBcd, mdayBcd, monBcd, yearBcd})); // R7

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrMask == 7'd0 && secBcd == 8'h59) |=> (secBcd == 8'h59 || secBcd == 8'h00)); // R2

  AST_MIN_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrMask == 7'd0 && secBcd != 8'h59) |=> $stable(minBcd)); // R2

  AST_WDAY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrMask == 7'd0 && wdayBcd <= 8'h06) |=>
      (wdayBcd == $past(wdayBcd) ||
       wdayBcd == (($past(wdayBcd) == 8'h06) ? 8'h00 : $past(wdayBcd) + 8'h01))); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrMask[0] && wrSec[3:0] <= 4'd9 && wrSec[7:4] <= 4'd9) |=>
      secBcd == $past(wrSec)); // R10
endmodule

bind bcd_calendar bcd_calendar_chk i_chk (.*);

// File: tb/test_bcd_calendar.sv
`timescale 1ns/1ps
module test_bcd_calendar;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [6:0]  wrMask = '0;
  logic [7:0]  wrSec = '0, wrMin = '0, wrHour = '0, wrWday = '0, wrMday = '0, wrMon = '0;
  logic [11:0] wrYear = '0;
  logic [7:0]  secBcd, minBcd, hourBcd, wdayBcd, mdayBcd, monBcd;
  logic [11:0] yearBcd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(T), .BASE_CENTURY(2000)) i_bcd_calendar (.*);

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag, input logic [7:0] s, m, h, w, d, mo,
                        input logic [11:0] y);
    chk({tag, " sec"},  {4'h0, secBcd},  {4'h0, s});
    chk({tag, " min"},  {4'h0, minBcd},  {4'h0, m});
    chk({tag, " hour"}, {4'h0, hourBcd}, {4'h0, h});
    chk({tag, " wday"}, {4'h0, wdayBcd}, {4'h0, w});
    chk({tag, " mday"}, {4'h0, mdayBcd}, {4'h0, d});
    chk({tag, " mon"},  {4'h0, monBcd},  {4'h0, mo});
    chk({tag, " year"}, yearBcd, y);
  endtask

  // Loads all fields on the edge that samples the enable rise; returns just after it.
  task automatic load(input logic [7:0] s, m, h, w, d, mo, input logic [11:0] y);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    enable = 1'b1; wrMask = 7'h7F;
    wrSec = s; wrMin = m; wrHour = h; wrWday = w; wrMday = d; wrMon = mo; wrYear = y;
    @(negedge clk) wrMask = '0;
  endtask

  task automatic stepCase(input string tag, input logic [7:0] s, m, h, w, d, mo,
                          input logic [11:0] y, input logic [7:0] es, em, eh, ew, ed, emo,
                          input logic [11:0] ey);
    load(s, m, h, w, d, mo, y);
    chkAll({tag, " loaded R11"}, s, m, h, w, d, mo, y);
    repeat (T) @(negedge clk);
    chkAll(tag, es, em, eh, ew, ed, emo, ey);
  endtask

  task automatic testReset();
    chkAll("R9 reset", 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
  endtask

  task automatic testTiming();
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
    repeat (T - 1) @(negedge clk);
    chk("R1 before first step", {4'h0, secBcd}, 12'h000);
    @(negedge clk);
    chk("R1 first step", {4'h0, secBcd}, 12'h001);
    repeat (T - 1) @(negedge clk);
    chk("R1 between steps", {4'h0, secBcd}, 12'h001);
    @(negedge clk);
    chk("R1 second step", {4'h0, secBcd}, 12'h002);
  endtask

  task automatic testStop();
    load(8'h12, 8'h13, 8'h14, 8'h02, 8'h15, 8'h06, 12'h321);
    @(negedge clk) enable = 1'b0;
    repeat (3 * T) @(negedge clk);
    chkAll("R7 stopped", 8'h12, 8'h13, 8'h14, 8'h02, 8'h15, 8'h06, 12'h321);
    wrMask = 7'h7F; wrSec = 8'h30; wrMin = 8'h31; wrHour = 8'h05; wrWday = 8'h04;
    wrMday = 8'h09; wrMon = 8'h03; wrYear = 12'h111;
    @(negedge clk) wrMask = '0;
    @(negedge clk);
    chkAll("R8 write while off", 8'h12, 8'h13, 8'h14, 8'h02, 8'h15, 8'h06, 12'h321);
  endtask

  task automatic testPriority();
    load(8'h59, 8'h34, 8'h12, 8'h01, 8'h10, 8'h05, 12'h050);
    repeat (T - 1) @(negedge clk);
    wrMask = 7'h01; wrSec = 8'h10;
    @(negedge clk) wrMask = '0;
    chk("R10 written sec", {4'h0, secBcd}, 12'h010);
    chk("R10 carried min", {4'h0, minBcd}, 12'h035);
    chk("R10 hour kept", {4'h0, hourBcd}, 12'h012);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    stepCase("R2 minute carry", 8'h59, 8'h20, 8'h10, 8'h03, 8'h11, 8'h07, 12'h024,
             8'h00, 8'h21, 8'h10, 8'h03, 8'h11, 8'h07, 12'h024);
    stepCase("R2 R3 day end", 8'h59, 8'h59, 8'h23, 8'h06, 8'h11, 8'h07, 12'h024,
             8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h07, 12'h024);
    stepCase("R4 30-day month", 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 12'h024,
             8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 12'h024);
    stepCase("R4 31-day month", 8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 12'h024,
             8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h02, 12'h024);
    stepCase("R5 leap 2024 feb28", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 12'h024,
             8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 12'h024);
    stepCase("R5 leap 2024 feb29", 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 12'h024,
             8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 12'h024);
    stepCase("R5 plain 2023 feb28", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 12'h023,
             8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 12'h023);
    stepCase("R5 century 2100", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 12'h100,
             8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 12'h100);
    stepCase("R5 400 rule 2000", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 12'h000,
             8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 12'h000);
    stepCase("R6 year end", 8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 12'h499,
             8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h01, 12'h500);
    stepCase("R6 year wrap", 8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 12'h999,
             8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
    testStop();
    testPriority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule